// File: doc/BRIEF.md
# Segment Paging Unit

This block widens a 16-bit processor address into a 22-bit physical address so that a small processor can reach a 4 MB space in 16 KB banks. The processor space is cut into four 16 KB segments. The two top address bits pick the segment, and each segment owns an 8-bit page register. The page value forms the upper bits of the physical address and the low fourteen processor address bits pass through unchanged.

Software sets the four page registers through a run of four consecutive I/O ports starting at `B0`. The port at `B0` holds the segment at `0000`, and each following port holds the next segment up to `C000`. The same ports read the registers back. Reset clears all four registers, so every segment shows bank 0, which is where the boot ROM lives, and the processor can start from any address. A flag marks accesses that land in the top four banks, 64 KB of RAM that the processor shares with the video chip. Banks `F8` to `FB` form the next 64 KB of RAM in a 128 KB configuration, and bank 1 holds the rest of the ROM. Neither of these raises the flag.

Top module: `seg_pager`

## Requirements
- R1: The segment is chosen by `cpu_addr[15:14]`. Value 0 uses the register at port `B0`, 1 uses `B1`, 2 uses `B2` and 3 uses `B3`.
- R2: `phys_addr[21:14]` is the chosen segment's page value and `phys_addr[13:0]` equals `cpu_addr[13:0]`. Both follow the inputs combinationally.
- R3: Suppose `io_wr` is high at a rising clock edge with `io_addr` equal to `B0`+n (n = 0..3). Register n then takes `io_wdata`, and the new value appears on `phys_addr` and on read-back right after that edge.
- R4: While `io_rd` is high and `io_addr` is in `B0`..`B3`, `io_rd_hit` is 1 and `io_rdata` shows the addressed register in the same cycle.
- R5: For any other port address, `io_rd_hit` is 0 and `io_rdata` is 0. A write to such a port changes no page register.
- R6: While `rst_n` is low, all four registers are cleared to 0 and writes are ignored. After reset, every segment maps to bank `00`.
- R7: `shared_ram` is 1 exactly when the chosen page has its top six bits all set (pages `FC` to `FF`). Pages `F8` to `FB`, `00` and `01` do not raise it.
- R8: A read and a write to the same port in the same cycle return the old register value. The new value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor memory address |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| phys_addr | output | 22 | Expanded physical address |
| io_rdata | output | 8 | I/O read data (0 when the port is not decoded) |
| io_rd_hit | output | 1 | High when a read addresses a page register |
| shared_ram | output | 1 | Chosen page lies in the video-shared RAM |

## Verification
The translation, read-back and shared-RAM flag are combinational. The bench therefore checks them in the same cycle as the stimulus, a couple of nanoseconds after it changes the inputs on the falling clock edge. Register writes take effect at the one rising edge that captures the strobe. Each write is held across exactly one rising edge, and the effect is checked at the following falling edge. This includes the same-cycle read that must still show the old value. The bench keeps its own copy of the four page values, updates it only when a write is captured, and computes every expected output from that copy.

// File: rtl/seg_pager_pkg.sv
package seg_pager_pkg;
    localparam int PAGE_W   = 8;
    localparam int SEG_SEL  = 2;
    localparam int NSEG     = 1 << SEG_SEL;
    localparam int CPU_W    = 16;
    localparam int OFF_W    = CPU_W - SEG_SEL;
    localparam int PHYS_W   = PAGE_W + OFF_W;
    localparam int IO_W     = 8;
    localparam logic [IO_W-1:0] PORT_BASE = 8'hB0;
    localparam int SHARED_TOP = 6;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        page_t [NSEG-1:0] page;
    } pg_state_t;
endpackage

// File: rtl/seg_port_decode.sv
module seg_port_decode
    import seg_pager_pkg::*;
#(
    parameter int               P_IO_W  = IO_W,
    parameter int               P_SEL   = SEG_SEL,
    parameter logic [P_IO_W-1:0] P_BASE = PORT_BASE
) (
    input  logic [P_IO_W-1:0] io_addr,
    output logic              hit,
    output logic [P_SEL-1:0]  idx
);
    always_comb begin
        hit = (io_addr[P_IO_W-1:P_SEL] == P_BASE[P_IO_W-1:P_SEL]);
        idx = io_addr[P_SEL-1:0];
    end
endmodule

// File: rtl/seg_page_regs.sv
module seg_page_regs
    import seg_pager_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEG_SEL-1:0] wr_idx,
    input  page_t              wr_data,
    output pg_state_t          state
);
    pg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSEG; i++) begin
            if (wr_en && (wr_idx == SEG_SEL'(i))) begin
                st_d.page[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/seg_translate.sv
module seg_translate
    import seg_pager_pkg::*;
(
    input  pg_state_t           state,
    input  logic [CPU_W-1:0]    cpu_addr,
    output logic [PHYS_W-1:0]   phys_addr,
    output logic                shared_ram
);
    localparam int SEL_LO = CPU_W - SEG_SEL;

    logic [SEG_SEL-1:0] seg;
    page_t              pg;

    always_comb begin
        seg        = cpu_addr[CPU_W-1:SEL_LO];
        pg         = state.page[seg];
        phys_addr  = {pg, cpu_addr[OFF_W-1:0]};
        shared_ram = &pg[PAGE_W-1:PAGE_W-SHARED_TOP];
    end
endmodule

// File: rtl/seg_pager.sv
module seg_pager
    import seg_pager_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [21:0]       phys_addr,
    output logic [7:0]        io_rdata,
    output logic              io_rd_hit,
    output logic              shared_ram
);
    logic               port_hit;
    logic [SEG_SEL-1:0] port_idx;
    pg_state_t          state;

    seg_port_decode u_dec (
        .io_addr (io_addr),
        .hit     (port_hit),
        .idx     (port_idx)
    );

    seg_page_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (io_wr && port_hit),
        .wr_idx  (port_idx),
        .wr_data (io_wdata),
        .state   (state)
    );

    seg_translate u_xlat (
        .state      (state),
        .cpu_addr   (cpu_addr),
        .phys_addr  (phys_addr),
        .shared_ram (shared_ram)
    );

    always_comb begin
        io_rd_hit = io_rd && port_hit;
        io_rdata  = io_rd_hit ? state.page[port_idx] : '0;
    end
endmodule

// File: rtl/seg_pager_chk.sv
module seg_pager_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [7:0]  io_wdata,
    input logic [21:0] phys_addr,
    input logic [7:0]  io_rdata,
    input logic        io_rd_hit,
    input logic        shared_ram
);
    logic in_range;
    assign in_range = (io_addr[7:2] == 6'b101100);

    // R2: offset bits pass straight through
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[13:0] == cpu_addr[13:0]);

    // R5: undecoded ports stay quiet
    assert_foreign_port_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (io_rdata == 8'h00 && !io_rd_hit));

    // R4: a read in range is flagged
    assert_read_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && in_range) |-> io_rd_hit);

    // R7: flag tracks the page bits on the physical address
    assert_shared_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shared_ram == (phys_addr[21:16] == 6'h3F));

    // R6: first cycle out of reset maps every segment to bank 0
    assert_reset_bank0_R6: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (phys_addr[21:14] == 8'h00));

    // R3: a captured write is visible on the following read-back
    assert_write_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(io_wr && in_range) && io_rd && (io_addr == $past(io_addr)))
        |-> (io_rdata == $past(io_wdata)));
endmodule

bind seg_pager seg_pager_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .phys_addr  (phys_addr),
    .io_rdata   (io_rdata),
    .io_rd_hit  (io_rd_hit),
    .shared_ram (shared_ram)
);

// File: tb/seg_pager_tb.sv
module seg_pager_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [21:0] phys_addr;
    logic [7:0]  io_rdata;
    logic        io_rd_hit;
    logic        shared_ram;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] model [4];
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_pager u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .phys_addr(phys_addr), .io_rdata(io_rdata), .io_rd_hit(io_rd_hit),
        .shared_ram(shared_ram)
    );

    function automatic logic [21:0] exp_phys(logic [15:0] a);
        return {model[a[15:14]], a[13:0]};
    endfunction

    function automatic logic exp_shared(logic [15:0] a);
        return model[a[15:14]][7:2] == 6'h3F;
    endfunction

    function automatic bit decoded(logic [7:0] p);
        return p >= 8'hB0 && p <= 8'hB3;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R1/R2/R7: translate one address and compare
    task automatic probe(logic [15:0] a, string req);
        @(negedge clk);
        cpu_addr = a;
        #2;
        check(req, 32'(phys_addr), 32'(exp_phys(a)));
        check("R7", 32'(shared_ram), 32'(exp_shared(a)));
    endtask

    // R3/R5: write held across exactly one rising edge
    task automatic io_write(logic [7:0] p, logic [7:0] d);
        @(negedge clk);
        io_addr = p; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        if (decoded(p) && rst_n) model[p[1:0]] = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // R4/R5: combinational read-back
    task automatic io_read(logic [7:0] p, string req);
        @(negedge clk);
        io_addr = p; io_rd = 1'b1;
        #2;
        check(req, 32'(io_rd_hit), decoded(p) ? 32'd1 : 32'd0);
        check(req, 32'(io_rdata), decoded(p) ? 32'(model[p[1:0]]) : 32'd0);
        io_rd = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
        // R6: writes during reset are ignored
        io_write(8'hB2, 8'h55);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) probe({s[1:0], 14'h2A5C}, "R6");
        for (int p = 0; p < 4; p++) io_read(8'hB0 + 8'(p), "R6");

        // R1: distinct pages per segment
        io_write(8'hB0, 8'h01);
        io_write(8'hB1, 8'hF8);
        io_write(8'hB2, 8'hFC);
        io_write(8'hB3, 8'hFF);
        for (int s = 0; s < 4; s++) probe({s[1:0], 14'h3FFF}, "R1");
        for (int s = 0; s < 4; s++) probe({s[1:0], 14'h0000}, "R2");
        // R7 boundaries: FB not shared, FC shared
        io_write(8'hB1, 8'hFB);
        probe(16'h4123, "R7");
        io_write(8'hB1, 8'hFC);
        probe(16'h7FFF, "R7");

        // R5: foreign ports change nothing and read zero
        io_write(8'hAF, 8'h77);
        io_write(8'hB4, 8'h66);
        io_write(8'h30, 8'h99);
        for (int s = 0; s < 4; s++) probe({s[1:0], 14'h1234}, "R5");
        io_read(8'hB4, "R5");
        io_read(8'hAF, "R5");

        // R8: read and write same port in one cycle
        @(negedge clk);
        io_addr = 8'hB3; io_wdata = 8'h3C; io_wr = 1'b1; io_rd = 1'b1;
        #2;
        check("R8", 32'(io_rdata), 32'(model[3]));
        @(posedge clk);
        model[3] = 8'h3C;
        @(negedge clk);
        io_wr = 1'b0;
        #2;
        check("R8", 32'(io_rdata), 32'h3C);
        io_rd = 1'b0;

        // R3: random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            int unsigned op = $urandom % 4;
            logic [7:0] p = ($urandom % 5 == 0) ? 8'($urandom) : (8'hB0 + 8'($urandom % 4));
            case (op)
                0: io_write(p, 8'($urandom));
                1: io_read(p, "R4");
                default: probe(16'($urandom), "R3");
            endcase
        end

        // R6: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) probe({s[1:0], 14'h0ABC}, "R6");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule